// File: doc/BRIEF.md
# Double-Buffered Crossbar Routing Commit

This block holds the live routing state of a 32-to-16 digital crossbar and performs the routing itself. Every output owns an active entry that names one input word and says whether the output is driven. A loader elsewhere builds a full set of staged (shadow) entries and raises a `newData` flag. The staged set reaches the active entries only when a separate configure strobe rises. That strobe is independent of any chip-select on the loader side, so several crossbars can be staged ahead of time and then switched together.

Two level-sensitive override inputs sit above the commit path. `ovReset` turns every output off and points it at input 0. `ovBcast` turns every output on and connects it to input 0. Both act on the outputs in the same cycle they are raised, with no clock edge needed. While either one is held, the active entries are rewritten each clock, so the forced routing remains after the override is released. Any input may feed any number of outputs. An output that is off drives an all-zero word and a low enable.

Top module: `xbar_commit`

## Requirements
- R1: After the system reset `rst_n` is released, every output is off (enable low, data zero) and every active entry selects input 0.
- R2: A commit happens on the clock edge where `cfgIn` is sampled high after having been sampled low, provided `newData` is high and no override is active. At that edge every active entry takes its shadow entry, and the new routing is visible in the following cycle. `cfgTaken` is high for exactly that one cycle. Holding `cfgIn` high gives no further commit.
- R3: A rising `cfgIn` while `newData` is low changes no routing and leaves `cfgTaken` low.
- R4: Shadow entry k occupies `shadowWords[6k+5:6k]`. Bits [4:0] of the entry give the input index, and bit 5 set to 1 means the output is off (0 means on). Any input may drive any number of outputs, including all 16.
- R5: While `ovReset` is high, all outputs are off in the same cycle with no clock edge needed. The active entries are cleared to input 0 and off, and the outputs stay off after release.
- R6: While `ovBcast` is high and `ovReset` is low, all outputs are on and carry input 0 in the same cycle. After release, the outputs stay on input 0.
- R7: An output that is off drives zero on its data word and holds its enable low.
- R8: With `ovReset` and `ovBcast` both high, reset wins and all outputs are off.
- R9: A rising `cfgIn` while either override is high is ignored: `cfgTaken` stays low and the routing follows the override. A later rising `cfgIn` with `newData` still high commits normally.
- R10: An output's data word follows changes of its selected input word in the same cycle, with no register in the data path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| inData | input | 256 | 32 input words of 8 bits; word i at bits [8i+7:8i] |
| shadowWords | input | 96 | 16 staged routing entries of 6 bits from the loader |
| newData | input | 1 | Loader flag: staged entries hold data not yet committed |
| cfgIn | input | 1 | Configure strobe; its sampled rising edge commits |
| ovReset | input | 1 | Level override: all outputs off, input 0 |
| ovBcast | input | 1 | Level override: all outputs on, input 0 |
| cfgTaken | output | 1 | One-cycle pulse in the commit cycle; the loader clears `newData` on it |
| outData | output | 128 | 16 output words of 8 bits; word k at bits [8k+7:8k] |
| outEn | output | 16 | Per-output enable; low means the output is off |

## Verification
A wrong active entry shows up at the ports in the cycle right after the faulty edge. The output then carries the wrong input word, or a zero word with a low enable where data was expected, and it stays that way until the next commit or override. A fault in edge detection or flag gating shows up in the commit cycle itself, as a wrong `cfgTaken` level, and one cycle later as routing that changed when it should not have. Faults in the override paths appear with no clock delay, because those paths act on the outputs combinationally.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  // Strobes from control to the routing datapath
  typedef struct packed {
    logic commit;      // copy shadow entries into active entries
    logic forceOff;    // reset override: off, input 0
    logic forceBcast;  // broadcast override: on, input 0
  } xbar_strobe_t;

endpackage

// File: rtl/xbar_ctrl.sv
module xbar_ctrl
  import xbar_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfgIn,
  input  logic         newData,
  input  logic         ovReset,
  input  logic         ovBcast,
  output xbar_strobe_t strobe,
  output logic         cfgTaken
);

  logic cfgPrev;
  logic cfgRise;
  logic anyOverride;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfgPrev <= 1'b0;
    else        cfgPrev <= cfgIn;
  end

  assign cfgRise     = cfgIn & ~cfgPrev;
  assign anyOverride = ovReset | ovBcast;

  always_comb begin
    strobe.forceOff   = ovReset;
    strobe.forceBcast = ovBcast & ~ovReset;
    strobe.commit     = cfgRise & newData & ~anyOverride;
  end

  assign cfgTaken = strobe.commit;

endmodule

// File: rtl/xbar_route.sv
module xbar_route
  import xbar_pkg::*;
#(
  parameter int NUM_IN  = 32,
  parameter int NUM_OUT = 16,
  parameter int DATA_W  = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  xbar_strobe_t                     strobe,
  input  logic [NUM_IN*DATA_W-1:0]         inData,
  input  logic [NUM_OUT*($clog2(NUM_IN)+1)-1:0] shadowWords,
  output logic [NUM_OUT*DATA_W-1:0]        outData,
  output logic [NUM_OUT-1:0]               outEn
);

  localparam int SEL_W   = $clog2(NUM_IN);
  localparam int ENTRY_W = SEL_W + 1;

  logic [DATA_W-1:0] inWord [NUM_IN];

  for (genvar i = 0; i < NUM_IN; i++) begin : g_unpack
    assign inWord[i] = inData[i*DATA_W +: DATA_W];
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    logic [SEL_W-1:0] selQ;
    logic             onQ;
    logic [SEL_W-1:0] shSel;
    logic             shOff;
    logic [SEL_W-1:0] effSel;
    logic             effOn;

    assign shSel = shadowWords[o*ENTRY_W +: SEL_W];
    assign shOff = shadowWords[o*ENTRY_W + SEL_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        selQ <= '0;
        onQ  <= 1'b0;
      end else if (strobe.forceOff) begin
        selQ <= '0;
        onQ  <= 1'b0;
      end else if (strobe.forceBcast) begin
        selQ <= '0;
        onQ  <= 1'b1;
      end else if (strobe.commit) begin
        selQ <= shSel;
        onQ  <= ~shOff;
      end
    end

    // Level overrides act on the outputs without waiting for a clock
    always_comb begin
      if (strobe.forceOff) begin
        effSel = '0;
        effOn  = 1'b0;
      end else if (strobe.forceBcast) begin
        effSel = '0;
        effOn  = 1'b1;
      end else begin
        effSel = selQ;
        effOn  = onQ;
      end
    end

    assign outEn[o]                      = effOn;
    assign outData[o*DATA_W +: DATA_W]   = effOn ? inWord[effSel] : '0;
  end

endmodule

// File: rtl/xbar_commit.sv
module xbar_commit
  import xbar_pkg::*;
#(
  parameter int NUM_IN  = 32,
  parameter int NUM_OUT = 16,
  parameter int DATA_W  = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NUM_IN*DATA_W-1:0]              inData,
  input  logic [NUM_OUT*($clog2(NUM_IN)+1)-1:0] shadowWords,
  input  logic                                  newData,
  input  logic                                  cfgIn,
  input  logic                                  ovReset,
  input  logic                                  ovBcast,
  output logic                                  cfgTaken,
  output logic [NUM_OUT*DATA_W-1:0]             outData,
  output logic [NUM_OUT-1:0]                    outEn
);

  xbar_strobe_t strobe;

  xbar_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfgIn    (cfgIn),
    .newData  (newData),
    .ovReset  (ovReset),
    .ovBcast  (ovBcast),
    .strobe   (strobe),
    .cfgTaken (cfgTaken)
  );

  xbar_route #(
    .NUM_IN  (NUM_IN),
    .NUM_OUT (NUM_OUT),
    .DATA_W  (DATA_W)
  ) u_route (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .inData      (inData),
    .shadowWords (shadowWords),
    .outData     (outData),
    .outEn       (outEn)
  );

endmodule

// File: rtl/xbar_commit_chk.sv
module xbar_commit_chk #(
  parameter int NUM_OUT = 16,
  parameter int DATA_W  = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      newData,
  input logic                      cfgIn,
  input logic                      ovReset,
  input logic                      ovBcast,
  input logic                      cfgTaken,
  input logic [NUM_OUT*DATA_W-1:0] outData,
  input logic [NUM_OUT-1:0]        outEn
);

  AST_TAKEN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfgTaken |=> !cfgTaken); // R2

  AST_TAKEN_NEEDS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    cfgTaken |-> cfgIn); // R2

  AST_TAKEN_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cfgTaken |-> newData); // R3

  AST_TAKEN_NO_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    cfgTaken |-> (!ovReset && !ovBcast)); // R9

  AST_ROUTE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfgTaken && !ovReset && !ovBcast) |=> ($stable(outEn) || ovReset || ovBcast)); // R3

  AST_RESET_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ovReset |-> (outEn == '0)); // R5

  AST_BCAST_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (ovBcast && !ovReset) |-> (outEn == '1)); // R6

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_off
    AST_OFF_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !outEn[o] |-> (outData[o*DATA_W +: DATA_W] == '0)); // R7
  end

endmodule

bind xbar_commit xbar_commit_chk #(
  .NUM_OUT (NUM_OUT),
  .DATA_W  (DATA_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .newData  (newData),
  .cfgIn    (cfgIn),
  .ovReset  (ovReset),
  .ovBcast  (ovBcast),
  .cfgTaken (cfgTaken),
  .outData  (outData),
  .outEn    (outEn)
);

// File: tb/xbar_commit_bench.sv
module xbar_commit_bench;

  localparam int NI = 32;
  localparam int NO = 16;
  localparam int DW = 8;
  localparam int EW = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NI*DW-1:0]  inData = '0;
  logic [NO*EW-1:0]  shadowWords = '0;
  logic              newData = 1'b0;
  logic              cfgIn = 1'b0;
  logic              ovReset = 1'b0;
  logic              ovBcast = 1'b0;
  logic              cfgTaken;
  logic [NO*DW-1:0]  outData;
  logic [NO-1:0]     outEn;

  int checks = 0;
  int failures = 0;

  // Behavioural reference state
  int mSel [NO];
  bit mOn  [NO];
  bit mPrev;
  bit mClear;

  always #10 clk = ~clk;

  xbar_commit u_xbar_commit (
    .clk(clk), .rst_n(rst_n), .inData(inData), .shadowWords(shadowWords),
    .newData(newData), .cfgIn(cfgIn), .ovReset(ovReset), .ovBcast(ovBcast),
    .cfgTaken(cfgTaken), .outData(outData), .outEn(outEn)
  );

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic bit expTaken();
    return cfgIn && !mPrev && newData && !ovReset && !ovBcast;
  endfunction

  task automatic checkAll(string tag);
    logic [NO-1:0]    eEn;
    logic [NO*DW-1:0] eData;
    for (int o = 0; o < NO; o++) begin
      int s;
      bit on;
      if (ovReset)      begin on = 0; s = 0; end
      else if (ovBcast) begin on = 1; s = 0; end
      else              begin on = mOn[o]; s = mSel[o]; end
      eEn[o] = on;
      eData[o*DW +: DW] = on ? inData[s*DW +: DW] : '0;
    end
    checks++;
    if (outEn !== eEn || outData !== eData) begin
      failures++;
      $display("FAIL %s routing: en=%h data=%h expected en=%h data=%h",
               tag, outEn, outData, eEn, eData);
    end
    checks++;
    if (cfgTaken !== expTaken()) begin
      failures++;
      $display("FAIL %s cfgTaken=%b expected %b", tag, cfgTaken, expTaken());
    end
  endtask

  task automatic updateModel();
    mClear = 0;
    if (ovReset) begin
      for (int o = 0; o < NO; o++) begin mSel[o] = 0; mOn[o] = 0; end
    end else if (ovBcast) begin
      for (int o = 0; o < NO; o++) begin mSel[o] = 0; mOn[o] = 1; end
    end else if (expTaken()) begin
      for (int o = 0; o < NO; o++) begin
        mSel[o] = int'(shadowWords[o*EW +: 5]);
        mOn[o]  = !shadowWords[o*EW + 5];
      end
      mClear = 1;
    end
    mPrev = cfgIn;
  endtask

  task automatic tick(string tag);
    #1;
    checkAll(tag);
    @(posedge clk);
    updateModel();
    @(negedge clk);
    if (mClear) newData = 1'b0;  // loader reacts to cfgTaken
  endtask

  task automatic setEntry(int o, int s, bit off);
    shadowWords[o*EW +: EW] = {off, 5'(s)};
  endtask

  task automatic fillInputs(int k);
    for (int i = 0; i < NI; i++) inData[i*DW +: DW] = 8'((i * k + 5) & 255);
  endtask

  task automatic pulseCfg(string tag);
    cfgIn = 1'b1; tick(tag);
    cfgIn = 1'b0; tick(tag);
  endtask

  initial begin
    for (int o = 0; o < NO; o++) begin mSel[o] = 0; mOn[o] = 0; end
    mPrev = 0;
    mClear = 0;
    fillInputs(3);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    tick("R1"); tick("R1");

    // R2: staged data without a strobe changes nothing, then commit
    for (int o = 0; o < NO; o++) setEntry(o, (o * 5 + 1) % 32, (o == 3) || (o == 9));
    newData = 1'b1;
    tick("R2"); tick("R2");
    cfgIn = 1'b1; tick("R2");
    // held strobe with fresh data: no second commit
    for (int o = 0; o < NO; o++) setEntry(o, 31 - o, 1'b0);
    newData = 1'b1;
    tick("R2"); tick("R2"); tick("R2");
    cfgIn = 1'b0; tick("R2");
    pulseCfg("R4");  // commits the reversed map with newData still set

    // R3: strobe without new data
    for (int o = 0; o < NO; o++) setEntry(o, 7, 1'b0);
    newData = 1'b0;
    pulseCfg("R3"); tick("R3");

    // R4: full fan-out from the top input
    for (int o = 0; o < NO; o++) setEntry(o, 31, 1'b0);
    newData = 1'b1;
    pulseCfg("R4");
    fillInputs(11); tick("R10");
    fillInputs(29); tick("R10");

    // R7: alternate outputs off
    for (int o = 0; o < NO; o++) setEntry(o, o + 16, o[0]);
    newData = 1'b1;
    pulseCfg("R7"); tick("R7");

    // R5: reset override, no clock needed
    ovReset = 1'b1; tick("R5"); tick("R5"); tick("R5");
    ovReset = 1'b0; tick("R5"); tick("R5");

    for (int o = 0; o < NO; o++) setEntry(o, (o * 3) % 32, 1'b0);
    newData = 1'b1;
    pulseCfg("R4");

    // R6: broadcast override
    ovBcast = 1'b1; tick("R6"); tick("R6");
    ovBcast = 1'b0; tick("R6");
    fillInputs(7); tick("R6");

    // R8: both overrides
    ovBcast = 1'b1; ovReset = 1'b1; tick("R8"); tick("R8");
    ovReset = 1'b0; tick("R8");
    ovBcast = 1'b0; tick("R8");

    // R9: strobe under override is ignored, flag retained
    for (int o = 0; o < NO; o++) setEntry(o, 2 * o, o == 5);
    newData = 1'b1;
    ovBcast = 1'b1; cfgIn = 1'b1; tick("R9");
    cfgIn = 1'b0; ovBcast = 1'b0; tick("R9"); tick("R9");
    pulseCfg("R9"); tick("R9");
    ovReset = 1'b1; cfgIn = 1'b1; newData = 1'b1; tick("R9");
    ovReset = 1'b0; cfgIn = 1'b0; tick("R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule